// File: doc/BRIEF.md
# MSI Inbound Vector Pending Decoder

This block takes message-signalled interrupt writes from an external bus master and turns each one into a single sticky pending bit. The written data word holds a 7-bit interrupt vector and a core-select bit. The vector picks one bit out of 128. Those bits are arranged as four 32-bit pending words for each core. The core-select bit picks which of the two processor banks receives the bit. The upper 16 bits of the word and the bits between the select bit and the vector are ignored.

Each core has an interrupt output. It is high whenever any of that core's pending bits is set. Software reads one pending word at a time through a registered read port. It acknowledges bits by writing ones to a chosen word of a chosen core. The message register answers at two addresses, one for the external bus window and one for the internal bus. It can be read back to see the last accepted select bit and vector.

Top module: `msi_pend_dec`

## Requirements
- R1: After a synchronous reset, `msg_rdata`, `irq` and every pending bit of both cores are zero.
- R2: A write with `wr_addr` equal to 0x0048 or 0x4048 is accepted. From the next clock on, `msg_rdata` returns the select bit in bit 15 and the vector in bits 6:0, with every other bit zero.
- R3: A write to any other address changes neither `msg_rdata` nor any pending bit.
- R4: An accepted write with vector v in data bits 6:0 sets bit (v mod 32) of pending word (v div 32). Data bits 31:16 and 14:7 have no effect on which bit is set.
- R5: Data bit 15 selects the bank: 0 selects core 0 and 1 selects core 1. Each accepted write sets at most one pending bit, and it sets no bit in the other core.
- R6: Pending bits are sticky. Only a clear can reset a bit, and writing an already-pending vector changes nothing.
- R7: When `clr_en` is high, each one in `clr_mask` clears the matching bit of word `clr_idx` of core `clr_core`. Zeros in the mask leave bits unchanged.
- R8: If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq[c]` is registered. In each cycle it equals the OR of core c's pending bits as they stood one clock earlier.
- R10: `pnd_rdata` is registered. It returns word `rd_idx` of core `rd_core` as that word stood at the clock edge where the request was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Message write strobe |
| wr_addr | input | 16 | Message write address offset |
| wr_data | input | 32 | Message write data |
| msg_rdata | output | 32 | Read-back of the message register |
| clr_en | input | 1 | Pending clear strobe |
| clr_core | input | 1 | Core whose pending word is cleared |
| clr_idx | input | 2 | Pending word index to clear |
| clr_mask | input | 32 | Write-one-to-clear mask |
| rd_core | input | 1 | Core of the pending word to read |
| rd_idx | input | 2 | Pending word index to read |
| pnd_rdata | output | 32 | Registered pending word read data |
| irq | output | 2 | Per-core interrupt request, one bit per core |

## Verification
A pending bit that is wrongly set or lost shows up in two places. The first is `pnd_rdata`, one clock after that word is read. The second is `irq`, one clock after the bank's last bit changes. Because of this, the bench reads every word at random and compares `irq` on every clock. A decoder that mixes up the word index and the bit index, or lets reserved bits through, puts a one in the wrong word. That error is visible on the first read of that word. A faulty address compare or a bad message-register update shows on `msg_rdata` on the very next clock.

// File: rtl/msi_pend_pkg.sv
package msi_pend_pkg;
  localparam int NCORE   = 2;
  localparam int SEL_BIT = 15;
  typedef enum logic {CORE_A = 1'b0, CORE_B = 1'b1} core_e;
endpackage

// File: rtl/msi_msg_decode.sv
module msi_msg_decode
  import msi_pend_pkg::*;
#(
  parameter int VEC_W   = 7,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] EXT_OFS = 16'h0048,
  parameter logic [ADDR_W-1:0] INT_OFS = 16'h4048,
  localparam int NBITS  = 2 ** VEC_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  output logic [NCORE-1:0][NBITS-1:0]   set_mask,
  output logic [WORD_W-1:0]             msg_rdata
);
  logic             hit;
  logic             sel;
  logic [VEC_W-1:0] vec;
  logic             sel_q;
  logic [VEC_W-1:0] vec_q;

  assign hit = wr_en && ((wr_addr == EXT_OFS) || (wr_addr == INT_OFS));
  assign sel = wr_data[SEL_BIT];
  assign vec = wr_data[VEC_W-1:0];

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_core
      always_comb begin
        set_mask[c] = '0;
        if (hit && (sel == c[0]))
          set_mask[c] = {{(NBITS-1){1'b0}}, 1'b1} << vec;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      vec_q <= '0;
    end else if (hit) begin
      sel_q <= sel;
      vec_q <= vec;
    end
  end

  always_comb begin
    msg_rdata                = '0;
    msg_rdata[SEL_BIT]       = sel_q;
    msg_rdata[VEC_W-1:0]     = vec_q;
  end
endmodule

// File: rtl/msi_pend_bank.sv
module msi_pend_bank #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int NBITS = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBITS-1:0]  set_mask,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [WORD_W-1:0] clr_mask,
  output logic [NBITS-1:0]  pend,
  output logic              irq
);
  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [WORD_W-1:0] clr_w;
      assign clr_w = (clr_en && (clr_idx == IDX_W'(w))) ? clr_mask : '0;
      always_ff @(posedge clk) begin
        if (rst)
          pend[w*WORD_W +: WORD_W] <= '0;
        else
          pend[w*WORD_W +: WORD_W] <= (pend[w*WORD_W +: WORD_W] & ~clr_w)
                                      | set_mask[w*WORD_W +: WORD_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend;
  end
endmodule

// File: rtl/msi_pend_dec.sv
module msi_pend_dec
  import msi_pend_pkg::*;
#(
  parameter int VEC_W  = 7,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EXT_OFS = 16'h0048,
  parameter logic [ADDR_W-1:0] INT_OFS = 16'h4048,
  localparam int NBITS  = 2 ** VEC_W,
  localparam int NWORDS = NBITS / WORD_W,
  localparam int IDX_W  = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] msg_rdata,
  input  logic              clr_en,
  input  logic              clr_core,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [WORD_W-1:0] clr_mask,
  input  logic              rd_core,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] pnd_rdata,
  output logic [NCORE-1:0]  irq
);
  logic [NCORE-1:0][NBITS-1:0] set_mask;
  logic [NCORE-1:0][NBITS-1:0] pend;

  msi_msg_decode #(
    .VEC_W(VEC_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .EXT_OFS(EXT_OFS), .INT_OFS(INT_OFS)
  ) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .set_mask(set_mask), .msg_rdata(msg_rdata)
  );

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_bank
      msi_pend_bank #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_bank (
        .clk(clk), .rst(rst), .set_mask(set_mask[c]),
        .clr_en(clr_en && (clr_core == c[0])), .clr_idx(clr_idx),
        .clr_mask(clr_mask), .pend(pend[c]), .irq(irq[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pnd_rdata <= '0;
    else     pnd_rdata <= pend[rd_core][rd_idx*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/msi_pend_chk.sv
module msi_pend_chk
  import msi_pend_pkg::*;
#(
  parameter int NBITS  = 128,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2,
  parameter logic [ADDR_W-1:0] EXT_OFS = 16'h0048,
  parameter logic [ADDR_W-1:0] INT_OFS = 16'h4048
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic [WORD_W-1:0]           msg_rdata,
  input logic                        clr_en,
  input logic                        clr_core,
  input logic [NCORE-1:0][NBITS-1:0] set_mask,
  input logic [NCORE-1:0][NBITS-1:0] pend,
  input logic [NCORE-1:0]            irq
);
  logic addr_ok;
  assign addr_ok = (wr_addr == EXT_OFS) || (wr_addr == INT_OFS);

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0) && (msg_rdata == '0));

  a_r3_stray_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_ok) |=> $stable(msg_rdata));

  a_r3_stray_no_set: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr_ok) |-> (set_mask == '0));

  a_r5_one_bit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_mask));

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_c
      a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        !(clr_en && (clr_core == c[0])) |=> ((pend[c] & $past(pend[c])) == $past(pend[c])));

      a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_mask[c] != '0) |=> ((pend[c] & $past(set_mask[c])) == $past(set_mask[c])));

      a_r9_irq_tracks: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq[c] == $past(|pend[c])));
    end
  endgenerate
endmodule

bind msi_pend_dec msi_pend_chk #(
  .NBITS(NBITS), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
  .EXT_OFS(EXT_OFS), .INT_OFS(INT_OFS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .msg_rdata(msg_rdata), .clr_en(clr_en), .clr_core(clr_core),
  .set_mask(set_mask), .pend(pend), .irq(irq)
);

// File: tb/msi_pend_dec_test.sv
`timescale 1ns/1ps
module msi_pend_dec_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] msg_rdata;
  logic        clr_en = 1'b0;
  logic        clr_core = 1'b0;
  logic [1:0]  clr_idx = '0;
  logic [31:0] clr_mask = '0;
  logic        rd_core = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] pnd_rdata;
  logic [1:0]  irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msi_pend_dec uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .msg_rdata(msg_rdata), .clr_en(clr_en), .clr_core(clr_core),
    .clr_idx(clr_idx), .clr_mask(clr_mask), .rd_core(rd_core),
    .rd_idx(rd_idx), .pnd_rdata(pnd_rdata), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_pend [2][4];
  logic [31:0] m_msg, m_rd;
  logic [1:0]  m_irq;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) for (int w = 0; w < 4; w++) m_pend[c][w] <= '0;
      m_msg <= '0; m_rd <= '0; m_irq <= '0;
    end else begin
      bit ok;
      ok = wr_en && (wr_addr == 16'h0048 || wr_addr == 16'h4048);
      for (int c = 0; c < 2; c++) begin
        logic any;
        any = 1'b0;
        for (int w = 0; w < 4; w++) begin
          logic [31:0] t;
          t = m_pend[c][w];
          any = any | (|t);
          if (clr_en && clr_core == c[0] && clr_idx == w[1:0]) t = t & ~clr_mask;
          if (ok && wr_data[15] == c[0] && int'(wr_data[6:0]) / 32 == w)
            t = t | (32'h1 << (int'(wr_data[6:0]) % 32));
          m_pend[c][w] <= t;
        end
        m_irq[c] <= any;
      end
      m_rd <= m_pend[rd_core][rd_idx];
      if (ok) m_msg <= {16'h0, wr_data[15], 8'h00, wr_data[6:0]};
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on && !rst && !done) begin
    chk("R2 msg_rdata vs model", msg_rdata, m_msg);
    chk("R9 irq vs model", {30'h0, irq}, {30'h0, m_irq});
    chk("R10 pnd_rdata vs model", pnd_rdata, m_rd);
  end

  task automatic step; @(negedge clk); endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; step; wr_en = 1'b0;
  endtask

  task automatic clr(input logic c, input logic [1:0] i, input logic [31:0] m);
    clr_en = 1'b1; clr_core = c; clr_idx = i; clr_mask = m; step; clr_en = 1'b0;
  endtask

  task automatic rd(input logic c, input logic [1:0] i, output logic [31:0] v);
    rd_core = c; rd_idx = i; step; v = pnd_rdata;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      done = 1; nchk++; nerr++;
      $display("FAIL watchdog expired");
      summary;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) step;
    rst = 1'b0;
    // R1: reset state
    chk("R1 msg_rdata", msg_rdata, 32'h0);
    chk("R1 irq", {30'h0, irq}, 32'h0);
    for (int c = 0; c < 2; c++) for (int w = 0; w < 4; w++) begin
      rd(c[0], w[1:0], v); chk("R1 pending", v, 32'h0);
    end
    cmp_on = 1;
    // R2 R4: external address, reserved bits set, vector 37 core 0
    wr(16'h0048, 32'hABCD_7FA5);
    chk("R2 readback ext", msg_rdata, 32'h0000_0025);
    chk("R9 irq not yet", {30'h0, irq}, 32'h0);
    rd(1'b0, 2'd1, v); chk("R4 vec37 word1 bit5", v, 32'h0000_0020);
    chk("R9 irq rises", {30'h0, irq}, 32'h1);
    rd(1'b1, 2'd1, v); chk("R5 other core untouched", v, 32'h0);
    rd(1'b0, 2'd0, v); chk("R5 single bit word0", v, 32'h0);
    // R2 R4 R5: internal address, core 1, top vector
    wr(16'h4048, 32'h0000_807F);
    chk("R2 readback int", msg_rdata, 32'h0000_807F);
    rd(1'b1, 2'd3, v); chk("R4 vec127 core1", v, 32'h8000_0000);
    // R4: word boundaries
    wr(16'h0048, 32'h0); wr(16'h4048, 32'h20); wr(16'h0048, 32'h40);
    rd(1'b0, 2'd0, v); chk("R4 vec0", v, 32'h1);
    rd(1'b0, 2'd1, v); chk("R4 vec32", v, 32'h21);
    rd(1'b0, 2'd2, v); chk("R4 vec64", v, 32'h1);
    rd(1'b0, 2'd3, v); chk("R4 word3 empty", v, 32'h0);
    // R3: stray address
    wr(16'h0049, 32'h0000_0001);
    chk("R3 msg unchanged", msg_rdata, 32'h0000_0040);
    rd(1'b0, 2'd0, v); chk("R3 no set", v, 32'h1);
    // R6: sticky re-set
    wr(16'h0048, 32'h25);
    rd(1'b0, 2'd1, v); chk("R6 sticky", v, 32'h21);
    // R7: clear
    clr(1'b0, 2'd1, 32'h20);
    rd(1'b0, 2'd1, v); chk("R7 w1c", v, 32'h1);
    // R8: set and clear same bit
    wr_en = 1'b1; wr_addr = 16'h0048; wr_data = 32'h0;
    clr_en = 1'b1; clr_core = 1'b0; clr_idx = 2'd0; clr_mask = 32'hFFFF_FFFF;
    step; wr_en = 1'b0; clr_en = 1'b0;
    rd(1'b0, 2'd0, v); chk("R8 set wins", v, 32'h1);
    // R9: irq falls one clock after last clear
    clr(1'b1, 2'd3, 32'hFFFF_FFFF);
    chk("R9 irq still high", {30'h0, irq}, 32'h3);
    step;
    chk("R9 irq falls", {30'h0, irq}, 32'h1);
    // random traffic compared against the model each clock
    for (int i = 0; i < 2000; i++) begin
      int a;
      a = $urandom % 4;
      wr_en = ($urandom % 2) == 0;
      wr_addr = (a == 0) ? 16'h0048 : (a == 1) ? 16'h4048 : (a == 2) ? 16'h0049 : 16'h4000;
      wr_data = $urandom;
      clr_en = ($urandom % 3) == 0;
      clr_core = $urandom; clr_idx = $urandom; clr_mask = $urandom;
      rd_core = $urandom; rd_idx = $urandom;
      step;
    end
    wr_en = 1'b0; clr_en = 1'b0;
    step;
    done = 1;
    summary;
  end
endmodule